// File: doc/BRIEF.md
# Port-Driven Coprocessor Instruction Controller

This block is the command front end of an arithmetic coprocessor that hangs off the four 8-bit I/O ports of a small microcontroller. The host places up to three operand bytes on the three data ports, then writes an opcode to the command port. That command write captures the opcode together with the current data-port values into a one-deep pending slot. The controller then either appends a byte to one of its wide operand registers, or launches a long datapath operation (full modular multiply-add or carry-propagate only) through a start/done handshake.

Because the host needs many cycles to assemble each command, the controller accepts the next command while an operation is still running. A launch that arrives while the datapath is busy is held in the pending slot and goes out as soon as the datapath reports completion. Byte loads are not held back by a running operation. The host polls the busy and pending flags. A command written while the slot is still occupied is discarded and latches a sticky overflow flag.

Top module: `coproc_ctrl`

## Requirements
- R1: After reset, busy, pending, overflow and dp_start are 0, and every operand register reads 0.
- R2: Opcode 0x01 (load) appends the p2 byte to register number p1. The register shifts left by 8, the new byte lands in bits 7:0, and bits above KBITS are lost. The load takes effect on the second clock edge after the command write.
- R3: A load whose p1 index is NREGS or higher changes no register.
- R4: The edge that samples a command write sets pending. Pending clears on the edge that executes the command.
- R5: A command written while pending is already 1 is discarded and sets overflow. Overflow stays 1 until reset, and the held command still executes unchanged.
- R6: Opcodes 0x02 (multiply-add) and 0x03 (carry-propagate) raise dp_start for exactly one cycle. They present dp_carry_only as 0 or 1 respectively, with dp_src_a = p1, dp_src_b = p2 and dp_dst = p3. When the datapath is idle, dp_start goes high on the second edge after the write.
- R7: busy rises together with dp_start and stays high until the edge on which dp_done is sampled high.
- R8: A launch that is pending while busy waits, and starts on the first edge at which busy is 0. Launches start in the order they were written. A load that is pending executes even while busy.
- R9: Any other opcode is consumed (pending clears) with no start and no register change.
- R10: dp_done while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_we | input | 1 | Command-port write strobe |
| p0_data | input | 8 | Opcode |
| p1_data | input | 8 | Operand byte 1 (register index / source A) |
| p2_data | input | 8 | Operand byte 2 (load byte / source B) |
| p3_data | input | 8 | Operand byte 3 (destination) |
| dp_done | input | 1 | Datapath completion pulse |
| rd_sel | input | IDXW | Register read-back select |
| busy | output | 1 | Datapath operation in progress |
| pending | output | 1 | Pending slot occupied |
| overflow | output | 1 | Sticky: a command was discarded |
| dp_start | output | 1 | One-cycle datapath launch |
| dp_carry_only | output | 1 | 0 = multiply-add, 1 = carry-propagate |
| dp_src_a | output | 8 | First source register index |
| dp_src_b | output | 8 | Second source register index |
| dp_dst | output | 8 | Destination register index |
| rd_data | output | KBITS | Contents of the selected register |

## Verification
The hardest situation to reach is a launch sitting in the pending slot behind a running operation, with a further command arriving before the slot drains. The bench gets there by using a long datapath latency in its done stub. It issues a multiply-add and then, while that operation is running, a load, a second launch and a third command. It then checks the order of the starts, the overflow flag, and which operands reached the datapath.

// File: rtl/coproc_ctrl.sv
module coproc_ctrl #(
  parameter int KBITS = 32,
  parameter int NREGS = 11,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p0_we,
  input  logic [7:0]       p0_data,
  input  logic [7:0]       p1_data,
  input  logic [7:0]       p2_data,
  input  logic [7:0]       p3_data,
  input  logic             dp_done,
  input  logic [IDXW-1:0]  rd_sel,
  output logic             busy,
  output logic             pending,
  output logic             overflow,
  output logic             dp_start,
  output logic             dp_carry_only,
  output logic [7:0]       dp_src_a,
  output logic [7:0]       dp_src_b,
  output logic [7:0]       dp_dst,
  output logic [KBITS-1:0] rd_data
);
  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_MADD  = 8'h02;
  localparam logic [7:0] OP_CPROP = 8'h03;

  logic [7:0] pend_op, pend_a, pend_b, pend_c;
  logic [KBITS-1:0] regs [NREGS];

  wire is_launch = (pend_op == OP_MADD) || (pend_op == OP_CPROP);
  wire issue_now = pending && (!is_launch || !busy);
  wire do_load   = issue_now && (pend_op == OP_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending       <= 1'b0;
      overflow      <= 1'b0;
      busy          <= 1'b0;
      dp_start      <= 1'b0;
      dp_carry_only <= 1'b0;
      dp_src_a      <= '0;
      dp_src_b      <= '0;
      dp_dst        <= '0;
      pend_op       <= '0;
      pend_a        <= '0;
      pend_b        <= '0;
      pend_c        <= '0;
    end else begin
      if (issue_now) pending <= 1'b0;
      if (p0_we) begin
        if (pending) overflow <= 1'b1;
        else begin
          pending <= 1'b1;
          pend_op <= p0_data;
          pend_a  <= p1_data;
          pend_b  <= p2_data;
          pend_c  <= p3_data;
        end
      end
      dp_start <= issue_now && is_launch;
      if (issue_now && is_launch) begin
        busy          <= 1'b1;
        dp_carry_only <= (pend_op == OP_CPROP);
        dp_src_a      <= pend_a;
        dp_src_b      <= pend_b;
        dp_dst        <= pend_c;
      end else if (dp_done) begin
        busy <= 1'b0;
      end
    end
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[r] <= '0;
      else if (do_load && pend_a == 8'(r)) regs[r] <= {regs[r][KBITS-9:0], pend_b};
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREGS; r++)
      if (rd_sel == IDXW'(r)) rd_data = regs[r];
  end
endmodule

// File: rtl/coproc_ctrl_chk.sv
module coproc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic p0_we,
  input logic dp_done,
  input logic busy,
  input logic pending,
  input logic overflow,
  input logic dp_start
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) dp_start |=> !dp_start);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) dp_start |-> busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && !dp_done |=> busy);
  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && dp_done |=> !busy);
  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy && dp_done |=> !busy);
  // R5
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n) pending && p0_we |=> overflow);
  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  // R8
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(dp_start) |-> $past(pending) && !$past(busy));
  // R4
  pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n) !pending && p0_we |=> pending);
endmodule

bind coproc_ctrl coproc_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .p0_we(p0_we), .dp_done(dp_done), .busy(busy),
  .pending(pending), .overflow(overflow), .dp_start(dp_start)
);

// File: tb/test_coproc_ctrl.sv
module test_coproc_ctrl;
  localparam int KBITS = 32;
  localparam int NREGS = 11;
  localparam int IDXW  = $clog2(NREGS);
  localparam int LAT   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0_we = 1'b0;
  logic [7:0] p0_data = '0, p1_data = '0, p2_data = '0, p3_data = '0;
  logic dp_done;
  logic force_done = 1'b0;
  logic [IDXW-1:0] rd_sel = '0;
  logic busy, pending, overflow, dp_start, dp_carry_only;
  logic [7:0] dp_src_a, dp_src_b, dp_dst;
  logic [KBITS-1:0] rd_data;

  always #4 clk = ~clk;

  coproc_ctrl #(.KBITS(KBITS), .NREGS(NREGS)) i_coproc_ctrl (
    .clk(clk), .rst_n(rst_n), .p0_we(p0_we), .p0_data(p0_data), .p1_data(p1_data),
    .p2_data(p2_data), .p3_data(p3_data), .dp_done(dp_done), .rd_sel(rd_sel),
    .busy(busy), .pending(pending), .overflow(overflow), .dp_start(dp_start),
    .dp_carry_only(dp_carry_only), .dp_src_a(dp_src_a), .dp_src_b(dp_src_b),
    .dp_dst(dp_dst), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, cnt = 0, starts = 0, fall_cyc = 0;
  logic prev_busy = 1'b0;
  logic [7:0] log_a [8];
  logic [7:0] log_b [8];
  logic [7:0] log_c [8];
  logic       log_op [8];
  int         log_cyc [8];
  logic [KBITS-1:0] expv [NREGS];

  assign dp_done = (cnt == 1) || force_done;

  always @(negedge clk) begin
    cyc++;
    if (dp_start) begin
      cnt = LAT;
      if (starts < 8) begin
        log_op[starts] = dp_carry_only; log_a[starts] = dp_src_a;
        log_b[starts] = dp_src_b; log_c[starts] = dp_dst; log_cyc[starts] = cyc;
      end
      starts++;
    end else if (cnt > 0) cnt--;
    if (prev_busy && !busy) fall_cyc = cyc;
    prev_busy = busy;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [7:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    @(negedge clk);
    p0_data = op; p1_data = a; p2_data = b; p3_data = c; p0_we = 1'b1;
    @(negedge clk);
    p0_we = 1'b0;
  endtask

  task automatic rd(int r, output logic [KBITS-1:0] v);
    rd_sel = IDXW'(r); #1; v = rd_data;
  endtask

  task automatic check_all_regs(string req);
    logic [KBITS-1:0] v;
    for (int r = 0; r < NREGS; r++) begin
      rd(r, v);
      check(req, v, expv[r]);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && (busy || pending); i++) cycles(1);
  endtask

  initial begin
    logic [KBITS-1:0] v;
    int s0;
    for (int r = 0; r < NREGS; r++) expv[r] = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 pending", pending, 0);
    check("R1 overflow", overflow, 0);
    check("R1 dp_start", dp_start, 0);
    check_all_regs("R1 regs");

    // R2 load sweep, more bytes than fit to show MSB loss; R4 pending timing
    for (int r = 0; r < NREGS; r++) begin
      for (int i = 0; i < KBITS/8 + 1; i++) begin
        logic [7:0] b;
        b = 8'(r * 17 + i * 29 + 3);
        issue(8'h01, 8'(r), b, 8'h00);
        if (r == 0 && i == 0) check("R4 pending set", pending, 1);
        cycles(1);
        if (r == 0 && i == 0) check("R4 pending clear", pending, 0);
        expv[r] = {expv[r][KBITS-9:0], b};
        rd(r, v);
        check("R2 load", v, expv[r]);
      end
    end
    check_all_regs("R2 all regs");

    // R3 out-of-range index
    issue(8'h01, 8'(NREGS), 8'h5A, 8'h00);
    cycles(1);
    issue(8'h01, 8'hFF, 8'hA5, 8'h00);
    cycles(1);
    check_all_regs("R3 regs unchanged");

    // R9 unknown opcodes
    s0 = starts;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'h00 : (k == 1) ? 8'h04 : (k == 2) ? 8'h7F : 8'hFF;
      issue(op, 8'h01, 8'h22, 8'h03);
      cycles(1);
      check("R9 pending clears", pending, 0);
    end
    cycles(2);
    check("R9 no start", starts, s0);
    check_all_regs("R9 regs unchanged");

    // R10 done while idle
    force_done = 1'b1; cycles(1); force_done = 1'b0; cycles(1);
    check("R10 busy", busy, 0);

    // R6 launch timing and fields
    s0 = starts;
    issue(8'h02, 8'h01, 8'h02, 8'h03);
    check("R6 not yet started", dp_start, 0);
    cycles(1);
    check("R6 dp_start", dp_start, 1);
    check("R7 busy with start", busy, 1);
    check("R6 op", dp_carry_only, 0);
    check("R6 fields", {dp_src_a, dp_src_b, dp_dst}, 24'h010203);
    cycles(1);
    check("R6 one cycle", dp_start, 0);

    // R8 load executes while busy
    issue(8'h01, 8'h05, 8'hC3, 8'h00);
    cycles(1);
    expv[5] = {expv[5][KBITS-9:0], 8'hC3};
    rd(5, v);
    check("R8 load while busy", v, expv[5]);
    check("R7 still busy", busy, 1);

    // R8 launch held behind running op
    issue(8'h03, 8'h04, 8'h05, 8'h06);
    cycles(1);
    check("R8 held pending", pending, 1);
    check("R8 no early start", starts, s0 + 1);
    for (int i = 0; i < 60 && starts < s0 + 2; i++) cycles(1);
    check("R8 second start", starts, s0 + 2);
    check("R8 order op", log_op[s0 + 1], 1);
    check("R8 order fields", {log_a[s0 + 1], log_b[s0 + 1], log_c[s0 + 1]}, 24'h040506);
    check("R8 starts after busy falls", log_cyc[s0 + 1], fall_cyc + 1);
    wait_idle();
    check("R7 idle after done", busy, 0);
    check("R5 no overflow yet", overflow, 0);

    // R5 overflow: running op, one held, one dropped
    s0 = starts;
    issue(8'h02, 8'h07, 8'h08, 8'h09);
    cycles(1);
    issue(8'h03, 8'h01, 8'h01, 8'h01);
    cycles(1);
    issue(8'h02, 8'h02, 8'h02, 8'h02);
    cycles(1);
    check("R5 overflow set", overflow, 1);
    wait_idle();
    cycles(LAT + 4);
    check("R5 dropped not started", starts, s0 + 2);
    check("R5 held fields", {log_op[s0 + 1], log_a[s0 + 1], log_c[s0 + 1]}, {1'b1, 16'h0101});
    check("R5 overflow sticky", overflow, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule